// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Guarded Event Flag

This block is one channel of a timer. A free-running counter value comes in from outside. The channel either samples that value when a chosen edge appears on its pin (capture mode) or signals an event when the counter reaches a programmed value (compare mode). Either kind of event sets a sticky flag. When the flag and its enable bit are both set, the interrupt request line is driven.

Software uses a small byte-wide bus to program the channel and to read its state. The bus reaches a control/status byte and the bytes of the channel value register. In compare mode that register holds the match value. In capture mode it holds the last sampled counter value.

The flag can only be cleared by a two-step handshake: first read the control byte while the flag is set, then write a zero to the flag bit. If an event arrives between those two steps, the handshake is cancelled, so a pending interrupt is never dropped.

Top module: `tcc_channel`

## Requirements
- R1: With mode bits [5:4] = 00 (capture), edge bits [3:2] select the event source: 01 rising pin edge, 10 falling pin edge, 11 either edge, 00 no event at all.
- R2: With mode bits [5:4] not 00 (compare), the flag sets on the clock edge where the counter first equals the value register. It sets only once per entry into equality.
- R3: A write to the control byte clears the flag only if it carries bit 7 = 0 and a read of the control byte with the flag at 1 came before it. A write without such a read leaves the flag set.
- R4: If an event occurs after the arming read and before the zero write, the flag stays at 1 after that write.
- R5: Writing 1 to bit 7 never sets the flag. Bits 6:0 (6 enable, 5:4 mode, 3:2 edge, 1 toggle-on-overflow, 0 max-duty) store the written value.
- R6: `irq_o` is 1 exactly when the flag and the enable bit (bit 6) are both 1. It updates on the same edge as the flag.
- R7: After reset, the control byte reads 0x00, the value register reads 0 and `irq_o` is 0.
- R8: A capture event loads the counter value into the value register on the same edge that sets the flag. Address 1 holds the low byte of that register and address 2 holds the next byte.
- R9: The pin passes through a two-stage synchronizer. A pin change made between clock edges sets the flag on the third rising clock edge after the change, and not before.
- R10: A read request gives `bus_rvalid_o` = 1 one cycle later. At that point `bus_rdata_o` holds the addressed byte. Address 0 is the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Free-running counter value |
| pin_i | input | 1 | Asynchronous channel pin |
| bus_rd_i | input | 1 | Read request |
| bus_wr_i | input | 1 | Write request |
| bus_addr_i | input | ADDR_W | Byte address (0 control, 1.. value bytes) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- an event always leaves the flag set;
- the flag falls only after an armed zero write;
- a write never raises the flag;
- a read with the flag set arms the clear;
- `irq_o` agrees with the flag and enable bits;
- a capture loads the counter value;
- a held compare match gives one event only.

Some behaviour only the bench scenarios can show. These are the race of a compare match landing between the arming read and the clearing write, the synchronizer latency counted in edges, the edge selection for each encoding, and the byte layout of the captured value as seen over the bus.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic [1:0] mode;
    logic [1:0] edge_sel;
    logic       tov;
    logic       maxd;
  } ctrl_t;

  localparam logic [1:0] MODE_CAPTURE = 2'b00;

  localparam logic [1:0] EDGE_OFF  = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

endpackage

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      last_q <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/tcc_event_det.sv
module tcc_event_det
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ref_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             evt_o,
  output logic             cap_o
);

  logic match, match_d, edge_hit, is_capture;

  assign match      = (cnt_i == ref_i);
  assign is_capture = (mode_i == MODE_CAPTURE);

  always_ff @(posedge clk) begin
    if (rst) match_d <= 1'b0;
    else     match_d <= match;
  end

  always_comb begin
    case (edge_sel_i)
      EDGE_RISE: edge_hit = rise_i;
      EDGE_FALL: edge_hit = fall_i;
      EDGE_BOTH: edge_hit = rise_i | fall_i;
      default:   edge_hit = 1'b0;
    endcase
  end

  assign cap_o = is_capture & edge_hit;
  assign evt_o = is_capture ? edge_hit : (match & ~match_d);

  // R2: a match held over several cycles yields one event only
  assert_compare_once_R2: assert property (@(posedge clk) disable iff (rst)
    (!is_capture && match && match_d) |-> !evt_o);

endmodule

// File: rtl/tcc_status_reg.sv
module tcc_status_reg
  import tcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       evt_i,
  output ctrl_t      ctrl_o,
  output logic       irq_o
);

  ctrl_t ctrl_q, ctrl_n;
  logic  arm_q, arm_n, irq_q;

  always_comb begin
    ctrl_n = ctrl_q;
    arm_n  = arm_q;
    if (wr_i) begin
      ctrl_n.ie       = wdata_i[6];
      ctrl_n.mode     = wdata_i[5:4];
      ctrl_n.edge_sel = wdata_i[3:2];
      ctrl_n.tov      = wdata_i[1];
      ctrl_n.maxd     = wdata_i[0];
      if (arm_q && !wdata_i[7]) ctrl_n.flag = 1'b0;
      arm_n = 1'b0;
    end else if (rd_i && ctrl_q.flag) begin
      arm_n = 1'b1;
    end
    if (evt_i) begin
      ctrl_n.flag = 1'b1;
      arm_n       = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      arm_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      arm_q  <= arm_n;
      irq_q  <= ctrl_n.flag & ctrl_n.ie;
    end
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;

  // R3: a read with the flag set arms the clear
  assert_arm_on_read_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !wr_i && ctrl_q.flag && !evt_i) |=> arm_q);
  // R3: the flag falls only after an armed zero write
  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_q.flag) |-> $past(wr_i && arm_q && !wdata_i[7]));
  // R4: an event always leaves the flag set
  assert_event_sets_R4: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> ctrl_q.flag);
  // R5: a write never raises the flag
  assert_no_set_by_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !evt_i && !ctrl_q.flag) |=> !ctrl_q.flag);
  // R6: request line agrees with flag and enable
  assert_irq_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q == (ctrl_q.flag && ctrl_q.ie));

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              pin_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);

  localparam int NBYTES = CNT_W / 8;

  logic             sel_ctrl, rise, fall, evt, cap;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] val_q;
  logic [7:0]       rd_mux, rdata_q;
  logic             rvalid_q;

  assign sel_ctrl = (bus_addr_i == '0);

  tcc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  tcc_event_det #(.CNT_W(CNT_W)) u_det (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .ref_i(val_q),
    .mode_i(ctrl.mode), .edge_sel_i(ctrl.edge_sel),
    .rise_i(rise), .fall_i(fall), .evt_o(evt), .cap_o(cap)
  );

  tcc_status_reg u_stat (
    .clk(clk), .rst(rst),
    .rd_i(bus_rd_i && sel_ctrl), .wr_i(bus_wr_i && sel_ctrl),
    .wdata_i(bus_wdata_i), .evt_i(evt),
    .ctrl_o(ctrl), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else if (cap) begin
      val_q <= cnt_i;
    end else if (bus_wr_i) begin
      for (int k = 0; k < NBYTES; k++)
        if (bus_addr_i == ADDR_W'(k + 1)) val_q[8*k +: 8] <= bus_wdata_i;
    end
  end

  always_comb begin
    rd_mux = ctrl;
    for (int k = 0; k < NBYTES; k++)
      if (bus_addr_i == ADDR_W'(k + 1)) rd_mux = val_q[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd_i;
      if (bus_rd_i) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  // R8: capture loads the counter value on the flag-setting edge
  assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
    cap |=> (val_q == $past(cnt_i)));
  // R10: read data is valid one cycle after the request
  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rd_i |=> bus_rvalid_o);

endmodule

// File: tb/test_tcc_channel.sv
`timescale 1ns/1ps
module test_tcc_channel;

  localparam int CNT_W  = 16;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CNT_W-1:0]  cnt = '0;
  logic              pin = 1'b0;
  logic              rd = 1'b0, wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              rvalid, irq;

  int ncmp = 0, nbad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  tcc_channel #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) i_tcc_channel (
    .clk(clk), .rst(rst), .cnt_i(cnt), .pin_i(pin),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  // monitor: pops expected bytes as read data appears
  always @(negedge clk) begin
    if (rvalid) begin
      ncmp++;
      if (exp_q.size() == 0) begin
        nbad++;
        $display("FAIL unexpected read data: actual %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          nbad++;
          $display("FAIL %s: read actual %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    ncmp++;
    if (irq !== e) begin
      nbad++;
      $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R7 reset state
    check_irq(1'b0, "R7");
    bus_read(0, 8'h00, "R7 ctrl");
    bus_read(1, 8'h00, "R7 val lo");
    bus_read(2, 8'h00, "R7 val hi");

    // R5 flag cannot be set by writing one; other bits stored
    bus_write(0, 8'hFF);
    bus_read(0, 8'h7F, "R5");
    bus_write(0, 8'h00);

    // R2 compare mode, R6 request line
    bus_write(0, 8'h50);
    bus_write(1, 8'h34);
    bus_write(2, 8'h12);
    bus_read(1, 8'h34, "R10 val lo");
    @(negedge clk); cnt = 16'h1233;
    @(negedge clk); cnt = 16'h1234;
    check_irq(1'b0, "R2 before match");
    @(negedge clk);
    check_irq(1'b1, "R2/R6 match");
    bus_read(0, 8'hD0, "R2 flag");

    // R3 armed clear
    bus_write(0, 8'h50);
    check_irq(1'b0, "R3 cleared");
    bus_read(0, 8'h50, "R3 cleared");

    // R3 write without arming read leaves flag set
    cnt = 16'h0000; idle(1);
    cnt = 16'h1234; idle(1);
    bus_write(0, 8'h50);
    bus_read(0, 8'hD0, "R3 unarmed write");
    cnt = 16'h0000; idle(1);

    // R4 race: match between arming read and zero write
    @(negedge clk);
    exp_q.push_back(8'hD0); tag_q.push_back("R4 arming read");
    rd = 1'b1; addr = 0;
    @(negedge clk);
    rd = 1'b0; cnt = 16'h1234;
    @(negedge clk);
    cnt = 16'h0000; wr = 1'b1; addr = 0; wdata = 8'h50;
    @(negedge clk);
    wr = 1'b0;
    check_irq(1'b1, "R4");
    bus_read(0, 8'hD0, "R4 flag kept");

    // R6 enable off masks request; that read armed, so this write clears
    bus_write(0, 8'h10);
    bus_read(0, 8'h10, "R3 clear");
    cnt = 16'h1234; idle(1);
    check_irq(1'b0, "R6 masked");
    bus_read(0, 8'h90, "R6 flag");
    cnt = 16'h0000;

    // R1/R8/R9 capture on rising edge
    cnt = 16'h0777;
    bus_write(0, 8'h44);
    bus_read(0, 8'h44, "R1 setup");
    pin = 1'b1;
    idle(2);
    check_irq(1'b0, "R9 not yet");
    idle(1);
    check_irq(1'b1, "R9 third edge");
    bus_read(0, 8'hC4, "R1 rise");
    bus_read(1, 8'h77, "R8 lo");
    bus_read(2, 8'h07, "R8 hi");
    bus_write(0, 8'h44);
    bus_read(0, 8'h44, "R3 clear cap");

    // R1 falling edge ignored in rise mode
    cnt = 16'h0888; pin = 1'b0; idle(5);
    bus_read(0, 8'h44, "R1 fall ignored");
    bus_read(1, 8'h77, "R1 no capture");

    // R1 both edges
    bus_write(0, 8'h4C);
    cnt = 16'h0999; pin = 1'b1; idle(4);
    bus_read(0, 8'hCC, "R1 both rise");
    bus_read(1, 8'h99, "R8 both rise");
    bus_write(0, 8'h4C);
    cnt = 16'h0AAA; pin = 1'b0; idle(4);
    bus_read(2, 8'h0A, "R8 both fall hi");
    bus_read(1, 8'hAA, "R8 both fall lo");
    bus_read(0, 8'hCC, "R1 both fall");

    // R1 edge select 00 disables capture
    bus_write(0, 8'h40);
    bus_read(0, 8'h40, "R1 off setup");
    cnt = 16'h0BBB; pin = 1'b1; idle(4);
    bus_read(0, 8'h40, "R1 off");
    bus_read(1, 8'hAA, "R1 off no capture");

    // R1 falling edge only
    bus_write(0, 8'h48);
    cnt = 16'h0CCC; pin = 1'b0; idle(4);
    bus_read(0, 8'hC8, "R1 fall");
    bus_read(1, 8'hCC, "R8 fall");

    idle(4);
    ncmp++;
    if (exp_q.size() != 0) begin
      nbad++;
      $display("FAIL R10: pending reads actual %0d expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

endmodule